// File: doc/BRIEF.md
# Frame-Sliced Trigger Input Selector

This block sits on a trigger bus of parallel lanes. Each lane carries 16-bit words, and the data of one event arrive as a train of frames, one per bunch crossing. A programmable selection list names words by frame number, lane and byte half. On the frame strobe that carries a selected word, the chosen byte goes through a programmable 8-bit lookup table. The result either replaces the value of a destination slot or is added, with saturation, into that slot. The slots together form a packed vector of 8-bit neural-network inputs.

An event-start pulse clears the vector and restarts the frame count. A done pulse follows the frame that carries the highest frame number used by the list. Software loads the list and the table through one write port before events are run.

Top module: `trig_input_selector`

## Requirements
- R1: After reset the vector is all zero and done is low. The frame count is idle, so strobes before the first event start change nothing. The lookup table resets to identity (entry a holds a).
- R2: An event-start pulse clears every slot and sets the frame count to 0. A frame strobe in the same cycle is ignored.
- R3: The k-th accepted strobe after an event start (k counted from 0) is frame k. An enabled list entry whose frame field equals k takes lane L, held at bus bits [16L+15:16L], and from it the low byte (select bit 0) or the high byte (select bit 1). The vector changes only on the cycle after an accepted strobe or an event start.
- R4: A write with table select 1 sets lookup entry cfg_addr to cfg_data[7:0]. Every selected byte is replaced by its lookup value before use.
- R5: An entry with accumulate flag 0 forwards its value into destination slot d, held at vec bits [8d+7:8d]. When several forwarding entries hit the same slot in one frame, the highest entry index wins.
- R6: An entry with accumulate flag 1 adds its value to the slot, and the sum saturates at 255. In a frame where a forwarding entry also hits the slot, the additions start from the forwarded value.
- R7: done is high for exactly one cycle, on the cycle after the accepted strobe whose frame number equals the largest frame field among enabled entries. That number is 0 when no entry is enabled.
- R8: At most 32 strobes are accepted per event; later strobes are ignored. An entry whose frame never arrives leaves its slot at zero.
- R9: A write with table select 0 and cfg_addr below the entry count loads entry cfg_addr from cfg_data bits: [4:0] frame, [7:5] lane, [8] byte select, [11:9] destination, [12] accumulate, [13] enable. An entry whose enable bit is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_start_i | input | 1 | Event start pulse |
| frame_vld_i | input | 1 | Frame strobe; bus_i valid |
| bus_i | input | 128 | Eight 16-bit lanes, lane L at [16L+15:16L] |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_tbl_i | input | 1 | 0 selects the list, 1 selects the lookup table |
| cfg_addr_i | input | 8 | Entry index or table address |
| cfg_data_i | input | 16 | Write data |
| vec_o | output | 64 | Eight 8-bit network inputs, slot d at [8d+7:8d] |
| done_o | output | 1 | One-cycle pulse after the last needed frame |

## Verification
A wrong frame count shows up as words taken from the wrong strobe, or as done firing on the wrong cycle; both are visible one cycle after the strobe in question. A corrupt table or entry register shows as a wrong byte in exactly one slot, on the cycle after the frame that uses it. A broken saturation or priority path shows only when several entries collide on one slot in one frame, so these collisions are provoked both directly and at random. The bench compares the whole vector and done on every cycle, so any divergence is caught on the first cycle it appears.

// File: rtl/tis_pkg.sv
package tis_pkg;
  localparam int unsigned N_LANES    = 8;
  localparam int unsigned LANE_W     = 16;
  localparam int unsigned N_FRAMES   = 32;
  localparam int unsigned FRAME_W    = $clog2(N_FRAMES);
  localparam int unsigned LANE_IDX_W = $clog2(N_LANES);
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned N_OUT      = 8;
  localparam int unsigned DEST_W     = $clog2(N_OUT);
  localparam int unsigned LUT_DEPTH  = 1 << BYTE_W;
  localparam int unsigned CFG_A_W    = 8;
  localparam int unsigned CFG_D_W    = 16;

  typedef struct packed {
    logic                  en;
    logic                  acc;
    logic [DEST_W-1:0]     dest;
    logic                  hi;
    logic [LANE_IDX_W-1:0] lane;
    logic [FRAME_W-1:0]    frame;
  } sel_entry_t;

  localparam int unsigned ENT_W = $bits(sel_entry_t);
endpackage

// File: rtl/tis_lut.sv
module tis_lut #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned W     = 8,
  parameter int unsigned N_RD  = 8,
  localparam int unsigned A_W  = $clog2(DEPTH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [A_W-1:0]          wr_addr_i,
  input  logic [W-1:0]            wr_data_i,
  input  logic [N_RD-1:0][A_W-1:0] rd_addr_i,
  output logic [N_RD-1:0][W-1:0]   rd_data_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= W'(i);
    end else if (we_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    assign rd_data_o[r] = mem_q[rd_addr_i[r]];
  end

  AST_LUT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(wr_addr_i)] == $past(wr_data_i)); // R4
endmodule

// File: rtl/tis_sel_list.sv
module tis_sel_list
  import tis_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [CFG_A_W-1:0]            addr_i,
  input  logic [CFG_D_W-1:0]            data_i,
  output sel_entry_t [N_ENTRIES-1:0]    ents_o,
  output logic [FRAME_W-1:0]            last_frame_o
);
  localparam int unsigned IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

  sel_entry_t [N_ENTRIES-1:0] ents_q;
  logic addr_ok;

  assign addr_ok = int'(addr_i) < N_ENTRIES;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ents_q <= '0;
    end else if (we_i && addr_ok) begin
      ents_q[addr_i[IDX_W-1:0]] <= sel_entry_t'(data_i[ENT_W-1:0]);
    end
  end

  // highest frame number that any enabled entry waits for
  always_comb begin
    last_frame_o = '0;
    for (int e = 0; e < N_ENTRIES; e++) begin
      if (ents_q[e].en && ents_q[e].frame > last_frame_o) last_frame_o = ents_q[e].frame;
    end
  end

  assign ents_o = ents_q;
endmodule

// File: rtl/tis_combine.sv
module tis_combine
  import tis_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 8,
  localparam int unsigned SUM_W = BYTE_W + $clog2(N_ENTRIES + 1)
) (
  input  sel_entry_t [N_ENTRIES-1:0]      ents_i,
  input  logic [N_ENTRIES-1:0]            hit_i,
  input  logic [N_ENTRIES-1:0][BYTE_W-1:0] val_i,
  input  logic [N_OUT-1:0][BYTE_W-1:0]    cur_i,
  output logic [N_OUT-1:0][BYTE_W-1:0]    nxt_o
);
  localparam logic [SUM_W-1:0] SAT = SUM_W'((1 << BYTE_W) - 1);

  logic [N_OUT-1:0][SUM_W-1:0] sum;

  for (genvar d = 0; d < N_OUT; d++) begin : g_slot
    always_comb begin
      logic [BYTE_W-1:0] base;
      base = cur_i[d];
      // later entries override earlier forwarding entries
      for (int e = 0; e < N_ENTRIES; e++) begin
        if (hit_i[e] && !ents_i[e].acc && int'(ents_i[e].dest) == d) base = val_i[e];
      end
      sum[d] = SUM_W'(base);
      for (int e = 0; e < N_ENTRIES; e++) begin
        if (hit_i[e] && ents_i[e].acc && int'(ents_i[e].dest) == d)
          sum[d] = sum[d] + SUM_W'(val_i[e]);
      end
      nxt_o[d] = (sum[d] > SAT) ? {BYTE_W{1'b1}} : sum[d][BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/trig_input_selector.sv
module trig_input_selector
  import tis_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        evt_start_i,
  input  logic                        frame_vld_i,
  input  logic [N_LANES*LANE_W-1:0]   bus_i,
  input  logic                        cfg_we_i,
  input  logic                        cfg_tbl_i,
  input  logic [CFG_A_W-1:0]          cfg_addr_i,
  input  logic [CFG_D_W-1:0]          cfg_data_i,
  output logic [N_OUT*BYTE_W-1:0]     vec_o,
  output logic                        done_o
);
  localparam int unsigned LUT_A_W = $clog2(LUT_DEPTH);

  sel_entry_t [N_ENTRIES-1:0]        ents;
  logic [FRAME_W-1:0]                last_frame;
  logic [N_ENTRIES-1:0]              hit;
  logic [N_ENTRIES-1:0][BYTE_W-1:0]  raw_byte;
  logic [N_ENTRIES-1:0][BYTE_W-1:0]  lut_val;
  logic [N_OUT-1:0][BYTE_W-1:0]      vec_q, vec_nxt;
  logic [LANE_W-1:0]                 lanes [N_LANES];
  logic [FRAME_W:0]                  frm_cnt_q;  // MSB set = idle / overrun
  logic                              accept;
  logic                              done_q;

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    assign lanes[l] = bus_i[l*LANE_W +: LANE_W];
  end

  tis_sel_list #(.N_ENTRIES(N_ENTRIES)) u_list (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (cfg_we_i && !cfg_tbl_i),
    .addr_i       (cfg_addr_i),
    .data_i       (cfg_data_i),
    .ents_o       (ents),
    .last_frame_o (last_frame)
  );

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
    logic [LANE_W-1:0] word;
    assign word        = lanes[ents[e].lane];
    assign raw_byte[e] = ents[e].hi ? word[LANE_W-1 -: BYTE_W] : word[BYTE_W-1:0];
    assign hit[e]      = ents[e].en && (ents[e].frame == frm_cnt_q[FRAME_W-1:0]);
  end

  tis_lut #(.DEPTH(LUT_DEPTH), .W(BYTE_W), .N_RD(N_ENTRIES)) u_lut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i && cfg_tbl_i),
    .wr_addr_i (cfg_addr_i[LUT_A_W-1:0]),
    .wr_data_i (cfg_data_i[BYTE_W-1:0]),
    .rd_addr_i (raw_byte),
    .rd_data_o (lut_val)
  );

  tis_combine #(.N_ENTRIES(N_ENTRIES)) u_comb (
    .ents_i (ents),
    .hit_i  (hit),
    .val_i  (lut_val),
    .cur_i  (vec_q),
    .nxt_o  (vec_nxt)
  );

  assign accept = frame_vld_i && !evt_start_i && !frm_cnt_q[FRAME_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frm_cnt_q <= {1'b1, {FRAME_W{1'b0}}};
      vec_q     <= '0;
      done_q    <= 1'b0;
    end else if (evt_start_i) begin
      frm_cnt_q <= '0;
      vec_q     <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= accept && (frm_cnt_q[FRAME_W-1:0] == last_frame);
      if (accept) begin
        frm_cnt_q <= frm_cnt_q + 1'b1;
        vec_q     <= vec_nxt;
      end
    end
  end

  assign vec_o  = vec_q;
  assign done_o = done_q;

  AST_CLEAR_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_start_i |=> (vec_o == '0) && !done_o); // R2
  AST_HOLD_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_start_i && !frame_vld_i) |=> $stable(vec_o) && !done_o); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_DONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(frame_vld_i && !evt_start_i)); // R7
  AST_OVERRUN_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_cnt_q[FRAME_W] && !evt_start_i) |=> $stable(vec_o) && !done_o); // R8
endmodule

// File: tb/trig_input_selector_tb_top.sv
`timescale 1ns/1ps
module trig_input_selector_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         evt_start = 1'b0;
  logic         frame_vld = 1'b0;
  logic [127:0] bus = '0;
  logic         cfg_we = 1'b0;
  logic         cfg_tbl = 1'b0;
  logic [7:0]   cfg_addr = '0;
  logic [15:0]  cfg_data = '0;
  logic [63:0]  vec;
  logic         done;

  int n_checks = 0;
  int n_fails  = 0;

  // reference state
  logic [13:0] m_ent [8];
  logic [7:0]  m_lut [256];
  logic [7:0]  m_vec [8];
  int          m_cnt;
  bit          m_done;

  always #2.5 clk = ~clk;

  trig_input_selector dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_start_i(evt_start), .frame_vld_i(frame_vld),
    .bus_i(bus), .cfg_we_i(cfg_we), .cfg_tbl_i(cfg_tbl), .cfg_addr_i(cfg_addr),
    .cfg_data_i(cfg_data), .vec_o(vec), .done_o(done)
  );

  function automatic int last_needed();
    int m = 0;
    for (int e = 0; e < 8; e++) if (m_ent[e][13] && int'(m_ent[e][4:0]) > m) m = int'(m_ent[e][4:0]);
    return m;
  endfunction

  function automatic logic [63:0] exp_vec();
    logic [63:0] v;
    for (int d = 0; d < 8; d++) v[d*8 +: 8] = m_vec[d];
    return v;
  endfunction

  // one frame of the reference: forwards by index order, then saturating adds
  function automatic void model_frame(logic [127:0] b);
    logic [7:0] nv [8];
    for (int d = 0; d < 8; d++) begin
      int s;
      logic [7:0] base = m_vec[d];
      for (int e = 0; e < 8; e++) begin
        logic [15:0] w = b[m_ent[e][7:5]*16 +: 16];
        logic [7:0] by = m_ent[e][8] ? w[15:8] : w[7:0];
        if (m_ent[e][13] && int'(m_ent[e][4:0]) == m_cnt && !m_ent[e][12] && int'(m_ent[e][11:9]) == d)
          base = m_lut[by];
      end
      s = int'(base);
      for (int e = 0; e < 8; e++) begin
        logic [15:0] w = b[m_ent[e][7:5]*16 +: 16];
        logic [7:0] by = m_ent[e][8] ? w[15:8] : w[7:0];
        if (m_ent[e][13] && int'(m_ent[e][4:0]) == m_cnt && m_ent[e][12] && int'(m_ent[e][11:9]) == d)
          s += int'(m_lut[by]);
      end
      nv[d] = (s > 255) ? 8'hFF : 8'(s);
    end
    for (int d = 0; d < 8; d++) m_vec[d] = nv[d];
  endfunction

  task automatic check_out(string tag);
    n_checks++;
    if (vec !== exp_vec()) begin
      n_fails++;
      $display("FAIL %s vec actual=%h expected=%h", tag, vec, exp_vec());
    end
    n_checks++;
    if (done !== m_done) begin
      n_fails++;
      $display("FAIL %s done actual=%b expected=%b", tag, done, m_done);
    end
  endtask

  task automatic cyc(string tag, bit ev, bit fv, logic [127:0] b, bit we, bit tbl,
                     logic [7:0] a, logic [15:0] dt);
    evt_start = ev; frame_vld = fv; bus = b;
    cfg_we = we; cfg_tbl = tbl; cfg_addr = a; cfg_data = dt;
    @(posedge clk);
    if (ev) begin
      for (int d = 0; d < 8; d++) m_vec[d] = 8'h00;
      m_cnt = 0; m_done = 1'b0;
    end else if (fv && m_cnt < 32) begin
      model_frame(b);
      m_done = (m_cnt == last_needed());
      m_cnt++;
    end else begin
      m_done = 1'b0;
    end
    if (we && tbl) m_lut[a] = dt[7:0];
    if (we && !tbl && a < 8) m_ent[a[2:0]] = dt[13:0];
    @(negedge clk);
    evt_start = 1'b0; frame_vld = 1'b0; cfg_we = 1'b0;
    check_out(tag);
  endtask

  task automatic wr_ent(int idx, bit en, bit acc, int dest, bit hi, int lane, int frame);
    logic [15:0] d = {2'b00, en, acc, 3'(dest), hi, 3'(lane), 5'(frame)};
    cyc("R9", 0, 0, '0, 1, 0, 8'(idx), d);
  endtask

  task automatic clear_ents();
    for (int e = 0; e < 8; e++) cyc("R9", 0, 0, '0, 1, 0, 8'(e), 16'h0000);
  endtask

  function automatic logic [127:0] lane_bus(int l, logic [15:0] w);
    logic [127:0] b = '0;
    b[l*16 +: 16] = w;
    return b;
  endfunction

  initial begin : watchdog
    #(200000 * 5);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin : main
    int seed = 7;
    void'($urandom(seed));
    for (int e = 0; e < 8; e++) m_ent[e] = '0;
    for (int a = 0; a < 256; a++) m_lut[a] = 8'(a);
    for (int d = 0; d < 8; d++) m_vec[d] = '0;
    m_cnt = 32; m_done = 1'b0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R1 reset");

    // R1: strobes before any event start are ignored
    wr_ent(0, 1, 0, 0, 0, 0, 0);
    cyc("R1 pre-event strobe", 0, 1, lane_bus(0, 16'h1234), 0, 0, 0, 0);

    // R3/R7: frame 0, identity table, done on frame 0
    cyc("R2 start", 1, 0, '0, 0, 0, 0, 0);
    cyc("R3 frame0 lo byte R7", 0, 1, lane_bus(0, 16'h1234), 0, 0, 0, 0);
    cyc("R7 done drops", 0, 0, '0, 0, 0, 0, 0);

    // R4: high byte of lane 5 at frame 2, remapped by table
    clear_ents();
    wr_ent(2, 1, 0, 3, 1, 5, 2);
    cyc("R4 lut write", 0, 0, '0, 1, 1, 8'hAB, 16'h005C);
    cyc("R2 start", 1, 0, '0, 0, 0, 0, 0);
    cyc("R3 frame0", 0, 1, lane_bus(5, 16'hAB00), 0, 0, 0, 0);
    cyc("R3 gap", 0, 0, '0, 0, 0, 0, 0);
    cyc("R3 frame1", 0, 1, lane_bus(5, 16'hAB00), 0, 0, 0, 0);
    cyc("R4 frame2 hi byte R7", 0, 1, lane_bus(5, 16'hAB00), 0, 0, 0, 0);

    // R6: saturation, forward then add in one frame
    clear_ents();
    cyc("R4 lut write", 0, 0, '0, 1, 1, 8'h10, 16'h00C8);
    wr_ent(0, 1, 1, 1, 0, 1, 1);
    wr_ent(1, 1, 1, 1, 0, 2, 1);
    wr_ent(3, 1, 0, 1, 0, 3, 1);
    cyc("R2 start", 1, 0, '0, 0, 0, 0, 0);
    cyc("R6 frame0", 0, 1, '0, 0, 0, 0, 0);
    cyc("R6 saturate", 0, 1, lane_bus(1, 16'h0010) | lane_bus(2, 16'h0010) | lane_bus(3, 16'h0003), 0, 0, 0, 0);

    // R5: two forwards to one slot, higher index wins
    clear_ents();
    wr_ent(4, 1, 0, 6, 0, 0, 0);
    wr_ent(6, 1, 0, 6, 0, 7, 0);
    cyc("R2 start", 1, 0, '0, 0, 0, 0, 0);
    cyc("R5 priority", 0, 1, lane_bus(0, 16'h0021) | lane_bus(7, 16'h0042), 0, 0, 0, 0);

    // R2: strobe coinciding with start is dropped
    cyc("R2 start with strobe", 1, 1, lane_bus(0, 16'h0099), 0, 0, 0, 0);
    cyc("R2 next is frame0", 0, 1, lane_bus(7, 16'h0077), 0, 0, 0, 0);

    // R8: frame 31 accepted, later strobes ignored; unreached entry stays zero
    clear_ents();
    wr_ent(0, 1, 0, 2, 0, 4, 31);
    wr_ent(1, 0, 0, 5, 0, 4, 3);  // R9 disabled entry
    cyc("R2 start", 1, 0, '0, 0, 0, 0, 0);
    for (int f = 0; f < 40; f++) cyc("R8 overrun", 0, 1, lane_bus(4, 16'(f + 1)), 0, 0, 0, 0);
    clear_ents();
    wr_ent(0, 1, 0, 2, 0, 4, 20);
    cyc("R2 start", 1, 0, '0, 0, 0, 0, 0);
    for (int f = 0; f < 5; f++) cyc("R8 frame not reached", 0, 1, lane_bus(4, 16'h0055), 0, 0, 0, 0);

    // random events
    for (int ev = 0; ev < 60; ev++) begin
      int nfr;
      for (int k = 0; k < 12; k++)
        cyc("R4 rand lut", 0, 0, '0, 1, 1, 8'($urandom), 16'($urandom));
      for (int e = 0; e < 8; e++) begin
        logic [15:0] d = 16'($urandom);
        d[4:0] = 5'($urandom_range(0, 9));
        cyc("R9 rand ent", 0, 0, '0, 1, 0, 8'(e), d);
      end
      cyc("R2 rand start", 1, ($urandom_range(0, 3) == 0), {$urandom, $urandom, $urandom, $urandom}, 0, 0, 0, 0);
      nfr = $urandom_range(0, 14);
      for (int f = 0; f < nfr; f++) begin
        if ($urandom_range(0, 2) == 0) cyc("R3 rand gap", 0, 0, '0, 0, 0, 0, 0);
        cyc("R3 R5 R6 R7 rand frame", 0, 1, {$urandom, $urandom, $urandom, $urandom}, 0, 0, 0, 0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule